// File: doc/BRIEF.md
# Split Virtqueue Ring Layout and Descriptor Chain Fetcher

This block turns a guest page number and a ring size into the three base addresses of a split virtqueue: descriptor table, available ring and used ring. It then pulls one pending request per fetch command. First it reads the guest-written available index. If that index shows pending work, it reads the next available ring slot to learn the head descriptor. Finally it walks the linked descriptors through a 64-bit read port, one request at a time.

Each descriptor in the chain leaves the block as one segment on a valid/ready stream. A segment carries its buffer address, its length and a direction bit. The bit is set for buffers the device may write and clear for buffers it may only read. When the chain ends, a one-cycle done pulse is raised. Alongside it the block presents the head index and the number of writable and readable segments. Two flags go with them: empty, when no request was pending, and error, when the chain exceeded the ring size. Buffer data is never moved here.

Top module: `vq_chain_fetch`

## Requirements
- R1: On `cfg_i`, the descriptor table base becomes `pfn_i` shifted left by 12 (4096-byte pages). A page number of zero leaves the queue unconfigured with all three bases zero.
- R2: The available ring base is the descriptor base plus 16 bytes times the ring size. The ring size is 2 to the power `ring_lg_i`, sampled on `cfg_i`.
- R3: The used ring base is the first 4096-byte boundary at or above available base + 4 + 2 × ring size.
- R4: A fetch first reads the word at the available ring base, whose bits [31:16] are the guest available index. If that equals the internal next-available index, the fetch ends with done and empty set. It makes no further read, emits no segment and leaves the index unchanged.
- R5: Otherwise the 16-bit head is read from byte address available base + 4 + 2 × (next index mod ring size), as 16-bit lane bits [2:1] of that address in its 8-byte word. The next index then increments by one, wrapping at 16 bits, and the head is reported on `head_o`.
- R6: Descriptor i is read as two words at descriptor base + 16 × (i mod ring size). Word 0 is the buffer address. Word 1 holds the length in [31:0], the flags in [47:32] and the next index in [63:48]. Segments leave in chain order.
- R7: The walk continues to the descriptor named by the next field while flag bit 0 is set, and ends after the first descriptor with bit 0 clear.
- R8: A descriptor with flag bit 1 set leaves with `seg_wr_o`=1 and counts in `n_in_o`; otherwise `seg_wr_o`=0 and it counts in `n_out_o`. Both counts restart at zero for each fetch.
- R9: A chain that still has bit 0 set on its ring-size-th descriptor ends after that descriptor with done and `err_o` set. Exactly ring-size segments are emitted. A chain of exactly ring-size descriptors ending cleanly sets no error.
- R10: `mem_req_o` holds with a stable 8-byte-aligned `mem_addr_o` until `mem_gnt_i`. Read data is taken from `mem_rdata_i` in the grant cycle.
- R11: While `seg_valid_o` is high and `seg_ready_i` low, the segment fields stay stable.
- R12: `fetch_i` is ignored while the queue is unconfigured. `cfg_i` clears the next-available index to zero and aborts any walk.
- R13: After reset, no read request, segment or done is raised, all bases read zero and the next index is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Load page number and ring size |
| pfn_i | input | PFN_W | Guest page number of the ring area |
| ring_lg_i | input | LG_W | log2 of ring size |
| fetch_i | input | 1 | Fetch one request |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read byte address, 8-byte aligned |
| mem_gnt_i | input | 1 | Read grant, data valid this cycle |
| mem_rdata_i | input | 64 | Read data |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Segment accepted |
| seg_addr_o | output | 64 | Segment buffer address |
| seg_len_o | output | 32 | Segment length |
| seg_wr_o | output | 1 | Segment is device-writable |
| done_o | output | 1 | Fetch finished (one cycle) |
| empty_o | output | 1 | Last fetch found no request |
| err_o | output | 1 | Last fetch hit the chain limit |
| head_o | output | 16 | Head descriptor index of last request |
| n_in_o | output | CNT_W | Writable segments of last request |
| n_out_o | output | CNT_W | Readable segments of last request |
| avail_next_o | output | 16 | Next-available index |
| desc_base_o | output | ADDR_W | Descriptor table base |
| avail_base_o | output | ADDR_W | Available ring base |
| used_base_o | output | ADDR_W | Used ring base |

## Verification
A wrong ring size mask or base value shows up on the very next read address. It misplaces the entry or descriptor word, and the segment then carries a wrong buffer address at its first handshake. A stale next-available index appears within one fetch as a false empty or a wrong head. Loop protection and index wrap need long chains and repeated fetches, so the bench builds an exactly ring-size chain, a looping one, and runs a sequence of fetches that crosses the ring end.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int WORD_W      = 64;
  localparam int IDX_W       = 16;
  localparam int LEN_W       = 32;
  localparam int DESC_BYTES  = 16;
  localparam int AVAIL_HDR   = 4;
  localparam int FLG_NEXT    = 0;
  localparam int FLG_WRITE   = 1;
  localparam int W1_FLG_LSB  = 32;
  localparam int W1_NXT_LSB  = 48;
  localparam int AIDX_LSB    = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AIDX, ST_ENT, ST_DLO, ST_DHI, ST_EMIT
  } walk_st_e;
endpackage

// File: rtl/vq_layout.sv
module vq_layout import vq_pkg::*; #(
  parameter int ADDR_W     = 64,
  parameter int PFN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int LG_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  logic [LG_W-1:0]   ring_lg_i,
  output logic [ADDR_W-1:0] desc_base_o,
  output logic [ADDR_W-1:0] avail_base_o,
  output logic [ADDR_W-1:0] used_base_o,
  output logic [LG_W-1:0]   ring_lg_o,
  output logic              live_o
);
  localparam logic [ADDR_W-1:0] PMASK = {{(ADDR_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};

  logic [ADDR_W-1:0] desc_n, avail_n, aend_n, used_n;
  logic              live_n;

  always_comb begin
    live_n  = (pfn_i != '0);
    desc_n  = ADDR_W'(pfn_i) << PAGE_SHIFT;
    avail_n = desc_n + (ADDR_W'(DESC_BYTES) << ring_lg_i);
    aend_n  = avail_n + ADDR_W'(AVAIL_HDR) + (ADDR_W'(2) << ring_lg_i);
    used_n  = (aend_n + PMASK) & ~PMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_base_o  <= '0;
      avail_base_o <= '0;
      used_base_o  <= '0;
      ring_lg_o    <= '0;
      live_o       <= 1'b0;
    end else if (cfg_i) begin
      live_o    <= live_n;
      ring_lg_o <= ring_lg_i;
      if (live_n) begin
        desc_base_o  <= desc_n;
        avail_base_o <= avail_n;
        used_base_o  <= used_n;
      end else begin
        desc_base_o  <= '0;
        avail_base_o <= '0;
        used_base_o  <= '0;
      end
    end
  end

  // R2: available ring sits above the table
  a_r2_avail_above_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> avail_base_o > desc_base_o);
  // R3: used ring on a later page, within one page of the avail end
  a_r3_used_above_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> (used_base_o > avail_base_o) && (used_base_o[PAGE_SHIFT-1:0] == '0));
  // R1: unconfigured queue exposes zero bases
  a_r1_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_o |-> (desc_base_o == '0) && (used_base_o == '0));
endmodule

// File: rtl/vq_addr_gen.sv
module vq_addr_gen import vq_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int LG_W   = 4
) (
  input  walk_st_e          st_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  input  logic [ADDR_W-1:0] avail_base_i,
  input  logic [LG_W-1:0]   ring_lg_i,
  input  logic [IDX_W-1:0]  avail_next_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        lane_o
);
  localparam int DSH = $clog2(DESC_BYTES);

  logic [IDX_W-1:0]  idx_mask, slot, dslot;
  logic [ADDR_W-1:0] ent_byte, dsc_byte;

  always_comb begin
    idx_mask = ~({IDX_W{1'b1}} << ring_lg_i);
    slot     = avail_next_i & idx_mask;
    dslot    = cur_idx_i & idx_mask;
    ent_byte = avail_base_i + ADDR_W'(AVAIL_HDR) + (ADDR_W'(slot) << 1);
    dsc_byte = desc_base_i + (ADDR_W'(dslot) << DSH);
    lane_o   = ent_byte[2:1];
    unique case (st_i)
      ST_AIDX: addr_o = avail_base_i;
      ST_ENT:  addr_o = {ent_byte[ADDR_W-1:3], 3'b000};
      ST_DLO:  addr_o = dsc_byte;
      ST_DHI:  addr_o = dsc_byte + ADDR_W'(8);
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/vq_walker.sv
module vq_walker import vq_pkg::*; #(
  parameter int LG_W  = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_i,
  input  logic              live_i,
  input  logic [LG_W-1:0]   ring_lg_i,
  input  logic              fetch_i,
  input  logic              gnt_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [1:0]        lane_i,
  input  logic              seg_ready_i,
  output walk_st_e          st_o,
  output logic [IDX_W-1:0]  cur_o,
  output logic [IDX_W-1:0]  avail_next_o,
  output logic              req_o,
  output logic              seg_valid_o,
  output logic [WORD_W-1:0] seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              seg_wr_o,
  output logic              done_o,
  output logic              empty_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [CNT_W-1:0]  n_in_o,
  output logic [CNT_W-1:0]  n_out_o
);
  walk_st_e         st;
  logic [15:0]      flags;
  logic [IDX_W-1:0] nxt, ent_val, guest_idx;
  logic [CNT_W-1:0] hops, hops_nx, ring_size;

  always_comb begin
    ent_val   = rdata_i[{lane_i, 4'b0000} +: IDX_W];
    guest_idx = rdata_i[AIDX_LSB +: IDX_W];
    ring_size = CNT_W'(1) << ring_lg_i;
    hops_nx   = hops + 1'b1;
    req_o     = (st == ST_AIDX) || (st == ST_ENT) || (st == ST_DLO) || (st == ST_DHI);
    seg_valid_o = (st == ST_EMIT);
    seg_wr_o  = flags[FLG_WRITE];
    st_o      = st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st           <= ST_IDLE;
      avail_next_o <= '0;
      cur_o        <= '0;
      head_o       <= '0;
      seg_addr_o   <= '0;
      seg_len_o    <= '0;
      flags        <= '0;
      nxt          <= '0;
      hops         <= '0;
      n_in_o       <= '0;
      n_out_o      <= '0;
      done_o       <= 1'b0;
      empty_o      <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (cfg_i) begin
        st           <= ST_IDLE;
        avail_next_o <= '0;
      end else begin
        unique case (st)
          ST_IDLE: if (fetch_i && live_i) begin
            st      <= ST_AIDX;
            empty_o <= 1'b0;
            err_o   <= 1'b0;
            n_in_o  <= '0;
            n_out_o <= '0;
            hops    <= '0;
          end
          ST_AIDX: if (gnt_i) begin
            if (guest_idx == avail_next_o) begin
              empty_o <= 1'b1;
              done_o  <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              st <= ST_ENT;
            end
          end
          ST_ENT: if (gnt_i) begin
            head_o       <= ent_val;
            cur_o        <= ent_val;
            avail_next_o <= avail_next_o + 1'b1;
            st           <= ST_DLO;
          end
          ST_DLO: if (gnt_i) begin
            seg_addr_o <= rdata_i;
            st         <= ST_DHI;
          end
          ST_DHI: if (gnt_i) begin
            seg_len_o <= rdata_i[LEN_W-1:0];
            flags     <= rdata_i[W1_FLG_LSB +: 16];
            nxt       <= rdata_i[W1_NXT_LSB +: IDX_W];
            st        <= ST_EMIT;
          end
          ST_EMIT: if (seg_ready_i) begin
            if (flags[FLG_WRITE]) n_in_o  <= n_in_o + 1'b1;
            else                  n_out_o <= n_out_o + 1'b1;
            hops <= hops_nx;
            if (!flags[FLG_NEXT]) begin
              done_o <= 1'b1;
              st     <= ST_IDLE;
            end else if (hops_nx == ring_size) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              cur_o <= nxt;
              st    <= ST_DLO;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: empty fetch reports no segments
  a_r4_empty_no_segs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && empty_o |-> (n_in_o == '0) && (n_out_o == '0));
  // R9: an aborted chain emitted exactly ring-size segments
  a_r9_err_full_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> (n_in_o + n_out_o) == ring_size);
  // R8: a finished non-empty request carries at least one segment
  a_r8_nonempty_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !empty_o |-> (n_in_o + n_out_o) != '0);
  // R7: request, segment and done phases never overlap
  a_r7_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, seg_valid_o, done_o}));
  // R11: a stalled segment keeps its fields
  a_r11_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i && !cfg_i |=>
      seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o) && $stable(seg_wr_o));
endmodule

// File: rtl/vq_chain_fetch.sv
module vq_chain_fetch import vq_pkg::*; #(
  parameter  int ADDR_W     = 64,
  parameter  int PFN_W      = 32,
  parameter  int PAGE_SHIFT = 12,
  parameter  int LG_MAX     = 15,
  localparam int LG_W       = $clog2(LG_MAX + 1),
  localparam int CNT_W      = LG_MAX + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  logic [LG_W-1:0]   ring_lg_i,
  input  logic              fetch_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [63:0]       seg_addr_o,
  output logic [31:0]       seg_len_o,
  output logic              seg_wr_o,
  output logic              done_o,
  output logic              empty_o,
  output logic              err_o,
  output logic [15:0]       head_o,
  output logic [CNT_W-1:0]  n_in_o,
  output logic [CNT_W-1:0]  n_out_o,
  output logic [15:0]       avail_next_o,
  output logic [ADDR_W-1:0] desc_base_o,
  output logic [ADDR_W-1:0] avail_base_o,
  output logic [ADDR_W-1:0] used_base_o
);
  logic [LG_W-1:0]  ring_lg;
  logic             live;
  walk_st_e         st;
  logic [IDX_W-1:0] cur_idx;
  logic [1:0]       lane;

  vq_layout #(
    .ADDR_W(ADDR_W), .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT), .LG_W(LG_W)
  ) u_layout (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .pfn_i(pfn_i),
    .ring_lg_i(ring_lg_i), .desc_base_o(desc_base_o), .avail_base_o(avail_base_o),
    .used_base_o(used_base_o), .ring_lg_o(ring_lg), .live_o(live)
  );

  vq_addr_gen #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_addr (
    .st_i(st), .desc_base_i(desc_base_o), .avail_base_i(avail_base_o),
    .ring_lg_i(ring_lg), .avail_next_i(avail_next_o), .cur_idx_i(cur_idx),
    .addr_o(mem_addr_o), .lane_o(lane)
  );

  vq_walker #(.LG_W(LG_W), .CNT_W(CNT_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .live_i(live),
    .ring_lg_i(ring_lg), .fetch_i(fetch_i), .gnt_i(mem_gnt_i),
    .rdata_i(mem_rdata_i), .lane_i(lane), .seg_ready_i(seg_ready_i),
    .st_o(st), .cur_o(cur_idx), .avail_next_o(avail_next_o), .req_o(mem_req_o),
    .seg_valid_o(seg_valid_o), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .seg_wr_o(seg_wr_o), .done_o(done_o), .empty_o(empty_o), .err_o(err_o),
    .head_o(head_o), .n_in_o(n_in_o), .n_out_o(n_out_o)
  );

  // R10: held request keeps its address until granted
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !cfg_i |=> mem_req_o && $stable(mem_addr_o));
  // R10: reads are word aligned
  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);
  // R12: no reads from an unconfigured queue
  a_r12_idle_unconf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> desc_base_o != '0);
endmodule

// File: tb/tb_vq_chain_fetch.sv
`timescale 1ns/1ps
module tb_vq_chain_fetch;
  localparam int ADDR_W = 64;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cfg, fetch;
  logic [31:0]       pfn;
  logic [3:0]        lg;
  logic              mem_req, mem_gnt;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_rdata;
  logic              seg_valid, seg_ready, seg_wr;
  logic [63:0]       seg_addr;
  logic [31:0]       seg_len;
  logic              done, empty, err;
  logic [15:0]       head, avail_next;
  logic [CNT_W-1:0]  n_in, n_out;
  logic [ADDR_W-1:0] desc_base, avail_base, used_base;

  logic [63:0] mem [0:1023];
  logic [7:0]  cyc = '0;
  logic        gnt_slow = 1'b0, rdy_slow = 1'b0;
  int          wd = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    wd  <= wd + 1;
  end
  assign mem_gnt   = mem_req & (gnt_slow ? cyc[0] : 1'b1);
  assign seg_ready = rdy_slow ? cyc[1] : 1'b1;
  assign mem_rdata = mem[mem_addr[12:3]];

  vq_chain_fetch dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .pfn_i(pfn), .ring_lg_i(lg),
    .fetch_i(fetch), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .seg_valid_o(seg_valid), .seg_ready_i(seg_ready),
    .seg_addr_o(seg_addr), .seg_len_o(seg_len), .seg_wr_o(seg_wr), .done_o(done),
    .empty_o(empty), .err_o(err), .head_o(head), .n_in_o(n_in), .n_out_o(n_out),
    .avail_next_o(avail_next), .desc_base_o(desc_base), .avail_base_o(avail_base),
    .used_base_o(used_base)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) if (wd > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  typedef struct packed {
    logic [31:0] p; logic [3:0] l; logic [63:0] d, a, u;
  } lay_t;
  localparam lay_t LAY [5] = '{
    '{32'h1,     4'd3,  64'h1000,     64'h1080,     64'h2000},
    '{32'h10,    4'd8,  64'h10000,    64'h11000,    64'h12000},
    '{32'h2,     4'd0,  64'h2000,     64'h2010,     64'h3000},
    '{32'hABCDE, 4'd15, 64'hABCDE000, 64'hABD5E000, 64'hABD6F000},
    '{32'h3,     4'd10, 64'h3000,     64'h7000,     64'h8000}
  };

  logic [63:0] sa [0:15];
  logic [31:0] sl [0:15];
  logic        sw [0:15];
  logic [63:0] ga [0:31];
  int nseg, ngnt;

  task automatic set_desc(input int i, input logic [63:0] a, input logic [31:0] l,
                          input logic [15:0] f, input logic [15:0] n);
    mem[(32'h1000 + 16*i) >> 3]     = a;
    mem[((32'h1000 + 16*i) >> 3) + 1] = {n, f, l};
  endtask
  task automatic set_aidx(input logic [15:0] v);
    mem[32'h1080 >> 3][31:16] = v;
  endtask
  task automatic set_ent(input int s, input logic [15:0] v);
    int b = 32'h1084 + 2*s;
    mem[b >> 3][((b >> 1) & 3)*16 +: 16] = v;
  endtask

  task automatic do_cfg(input logic [31:0] p, input logic [3:0] l);
    @(negedge clk); cfg = 1'b1; pfn = p; lg = l;
    @(negedge clk); cfg = 1'b0;
  endtask

  task automatic run_fetch(input string req);
    bit got = 0;
    nseg = 0; ngnt = 0;
    @(negedge clk); fetch = 1'b1;
    @(negedge clk); fetch = 1'b0;
    for (int k = 0; k < 600 && !got; k++) begin
      if (mem_req && mem_gnt) begin
        if (ngnt < 32) ga[ngnt] = mem_addr;
        ngnt++;
      end
      if (seg_valid && seg_ready) begin
        if (nseg < 16) begin sa[nseg] = seg_addr; sl[nseg] = seg_len; sw[nseg] = seg_wr; end
        nseg++;
      end
      if (done) got = 1;
      else @(negedge clk);
    end
    if (!got) chk(req, "fetch completion", 64'h0, 64'h1);
  endtask

  initial begin
    cfg = 0; fetch = 0; pfn = '0; lg = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "req", {63'h0, mem_req}, 64'h0);
    chk("R13", "seg_valid", {63'h0, seg_valid}, 64'h0);
    chk("R13", "done", {63'h0, done}, 64'h0);
    chk("R13", "used_base", used_base, 64'h0);
    chk("R13", "avail_next", {48'h0, avail_next}, 64'h0);
    rst_n = 1'b1;

    // R1 R2 R3: layout vectors
    for (int v = 0; v < 5; v++) begin
      do_cfg(LAY[v].p, LAY[v].l);
      chk("R1", "desc_base", desc_base, LAY[v].d);
      chk("R2", "avail_base", avail_base, LAY[v].a);
      chk("R3", "used_base", used_base, LAY[v].u);
    end

    do_cfg(32'h1, 4'd3);
    // R4: empty at index 0
    set_aidx(16'd0);
    run_fetch("R4");
    chk("R4", "empty", {63'h0, empty}, 64'h1);
    chk("R4", "reads", ngnt, 1);
    chk("R4", "segments", nseg, 0);
    chk("R4", "avail_next", {48'h0, avail_next}, 64'h0);

    // R5 R6: single readable descriptor
    set_aidx(16'd1); set_ent(0, 16'd5);
    set_desc(5, 64'h0000_1234_5678_9ABC, 32'd100, 16'h0, 16'h0);
    run_fetch("R5");
    chk("R5", "head", {48'h0, head}, 64'd5);
    chk("R5", "avail_next", {48'h0, avail_next}, 64'd1);
    chk("R5", "entry word addr", ga[1], 64'h1080);
    chk("R6", "desc word0 addr", ga[2], 64'h1050);
    chk("R6", "desc word1 addr", ga[3], 64'h1058);
    chk("R6", "seg count", nseg, 1);
    chk("R6", "seg addr", sa[0], 64'h0000_1234_5678_9ABC);
    chk("R6", "seg len", {32'h0, sl[0]}, 64'd100);
    chk("R8", "seg wr", {63'h0, sw[0]}, 64'h0);
    chk("R8", "n_out", {48'h0, n_out}, 64'd1);
    chk("R8", "n_in", {48'h0, n_in}, 64'd0);
    chk("R4", "empty clear", {63'h0, empty}, 64'h0);

    // R7 R8 R10 R11: three-link chain with stalls, next index taken mod size
    gnt_slow = 1'b1; rdy_slow = 1'b1;
    set_aidx(16'd2); set_ent(1, 16'd2);
    set_desc(2, 64'hA2A2, 32'd20, 16'h1, 16'd7);
    set_desc(7, 64'hA7A7, 32'd30, 16'h3, 16'h000C);
    set_desc(4, 64'hA4A4, 32'd40, 16'h2, 16'd0);
    run_fetch("R7");
    chk("R7", "seg count", nseg, 3);
    chk("R10", "entry word addr", ga[1], 64'h1080);
    chk("R6", "wrapped desc addr", ga[6], 64'h1040);
    chk("R7", "seg0 addr", sa[0], 64'hA2A2);
    chk("R7", "seg1 addr", sa[1], 64'hA7A7);
    chk("R7", "seg2 addr", sa[2], 64'hA4A4);
    chk("R11", "seg2 len", {32'h0, sl[2]}, 64'd40);
    chk("R8", "seg0 wr", {63'h0, sw[0]}, 64'h0);
    chk("R8", "seg1 wr", {63'h0, sw[1]}, 64'h1);
    chk("R8", "n_in", {48'h0, n_in}, 64'd2);
    chk("R8", "n_out", {48'h0, n_out}, 64'd1);
    chk("R5", "head", {48'h0, head}, 64'd2);
    gnt_slow = 1'b0; rdy_slow = 1'b0;

    // R4: empty at nonzero index
    run_fetch("R4");
    chk("R4", "empty at 2", {63'h0, empty}, 64'h1);
    chk("R4", "avail_next", {48'h0, avail_next}, 64'd2);

    // R9: exactly ring-size chain ends cleanly
    for (int i = 0; i < 8; i++)
      set_desc(i, 64'hB000 + 64'(i), 32'(i + 1), {14'h0, i[0], (i < 7) ? 1'b1 : 1'b0},
               16'(i + 1));
    set_aidx(16'd3); set_ent(2, 16'd0);
    run_fetch("R9");
    chk("R9", "full chain segs", nseg, 8);
    chk("R9", "full chain err", {63'h0, err}, 64'h0);
    chk("R9", "last seg addr", sa[7], 64'hB007);
    chk("R8", "n_in", {48'h0, n_in}, 64'd4);
    chk("R8", "n_out", {48'h0, n_out}, 64'd4);

    // R9: looping chain aborted
    set_desc(7, 64'hB007, 32'd8, 16'h3, 16'd0);
    set_aidx(16'd4); set_ent(3, 16'd0);
    run_fetch("R9");
    chk("R9", "loop err", {63'h0, err}, 64'h1);
    chk("R9", "loop segs", nseg, 8);

    // R5: slot index wraps at ring size
    set_desc(1, 64'hC001, 32'd11, 16'h0, 16'd0);
    set_desc(3, 64'hC003, 32'd13, 16'h0, 16'd0);
    for (int s = 4; s < 8; s++) set_ent(s, 16'd1);
    set_ent(0, 16'd3);
    set_aidx(16'd9);
    for (int f = 0; f < 4; f++) run_fetch("R5");
    chk("R5", "index after 8", {48'h0, avail_next}, 64'd8);
    run_fetch("R5");
    chk("R5", "wrapped slot head", {48'h0, head}, 64'd3);
    chk("R5", "wrapped entry addr", ga[1], 64'h1080);
    chk("R5", "index after 9", {48'h0, avail_next}, 64'd9);

    // R12: unconfigured queue ignores fetch
    do_cfg(32'h0, 4'd3);
    chk("R12", "desc_base zero", desc_base, 64'h0);
    begin
      int seen = 0;
      @(negedge clk); fetch = 1'b1;
      @(negedge clk); fetch = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (mem_req || done || seg_valid) seen++;
        @(negedge clk);
      end
      chk("R12", "activity while unconfigured", seen, 0);
    end

    // R12: cfg clears next index
    do_cfg(32'h1, 4'd3);
    chk("R12", "index cleared", {48'h0, avail_next}, 64'd0);
    set_aidx(16'd1); set_ent(0, 16'd1); set_ent(1, 16'd3);
    run_fetch("R12");
    chk("R12", "head after cfg", {48'h0, head}, 64'd1);

    report();
    $finish;
  end
endmodule